// File: doc/BRIEF.md
# Streaming Echo Verifier

This block confirms that a short record sent to a remote host came back unaltered. The host returns the record one byte at a time. Each returned byte is checked against the byte held at the same position in a small local reference memory as it arrives. The returned stream is never stored as a whole. Only the byte waiting for its compare is held, for one cycle.

The verifier drives the reference memory's read address and takes its read data back. The memory has one cycle of read latency by default. Once the configured number of bytes has been compared, a completion flag rises. The pass flag rises with it only if every byte agreed. Both flags then hold their value until reset. Bytes that arrive after the record is complete are dropped.

Top module: `echo_verify`

## Requirements
- R1: While and after reset (`rst` high, synchronous, active high), `memAddr` is 0, `checkDone` is 0 and `txGood` is 0.
- R2: Each byte accepted on a rising clock edge with `byteValid` high advances `memAddr` by exactly one. The address wraps modulo the memory depth, so with a depth of 4 it reads 0 again after the fourth byte.
- R3: The n-th accepted byte (counting from 0) is compared with the memory word at address n. The memory returns that word one cycle after the address is presented.
- R4: A mismatch on any byte, including a single-bit difference, keeps `txGood` low until the next reset. `checkDone` still rises when the count completes.
- R5: `txGood` is 1 only when all DEPTH bytes matched. Once high, it stays high through idle cycles and through later input until reset.
- R6: `checkDone` is 0 until the DEPTH-th byte is accepted. It becomes 1 one clock edge after that acceptance and stays 1 until reset.
- R7: Bytes presented after the DEPTH-th accepted byte are ignored. `memAddr`, `checkDone` and `txGood` do not change.
- R8: A reset in the middle of a transfer discards any partial result and any earlier mismatch. The next byte is compared against address 0.
- R9: Cycles with `byteValid` low do not advance the address and do not affect the verdict, wherever they fall in the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset that clears the check |
| byteValid | input | 1 | An echoed byte is present this cycle |
| echoByte | input | 8 | Echoed byte from the host |
| memAddr | output | 2 | Read address to the local reference memory |
| memRdData | input | 8 | Registered read data from the reference memory |
| checkDone | output | 1 | All expected bytes have been compared |
| txGood | output | 1 | Completed echo matched the stored record |

## Verification
The bench builds the verifier with its defaults: a depth of 4, 8-bit bytes and one cycle of read latency. At that size it can sweep every combination of byte position and flipped bit, which gives 32 mismatch streams. These streams are mixed with zero to two idle cycles between bytes. Several arithmetic reference patterns exercise the all-match path. Further streams cover overrun bytes after completion and a reset in the middle of a transfer, each compared against verdicts the bench works out from the stream contents.

// File: rtl/echo_verify_pkg.sv
package echo_verify_pkg;

  // Strobes issued by the sequencing logic to the compare datapath
  typedef struct packed {
    logic accept;   // an echo byte is taken this cycle
    logic compare;  // held byte and memory data are aligned this cycle
    logic lastCmp;  // this compare is the final one of the record
  } ctlStrobe_t;

endpackage

// File: rtl/echo_verify_ctl.sv
module echo_verify_ctl
  import echo_verify_pkg::*;
#(
  parameter int DEPTH    = 4,
  parameter int READ_LAT = 1,
  localparam int ADDR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byteValid,
  output logic [ADDR_W-1:0] memAddr,
  output ctlStrobe_t        strobe,
  output logic              checkDone
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] LAST_CMP = CNT_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

  logic [CNT_W-1:0] acceptCnt;
  logic [CNT_W-1:0] cmpCnt;
  logic             full;
  logic             accept;
  logic             compare;
  logic             doneQ;

  assign full   = (acceptCnt == FULL_CNT);
  assign accept = byteValid && !full;

  always_ff @(posedge clk) begin
    if (rst) begin
      acceptCnt <= '0;
    end else if (accept) begin
      acceptCnt <= acceptCnt + ONE_CNT;
    end
  end

  // Address wraps modulo DEPTH: after the last byte it is unused.
  always_comb begin
    if (full) memAddr = '0;
    else      memAddr = acceptCnt[ADDR_W-1:0];
  end

  generate
    if (READ_LAT == 1) begin : g_syncRead
      logic pend;
      always_ff @(posedge clk) begin
        if (rst) pend <= 1'b0;
        else     pend <= accept;
      end
      assign compare = pend;
    end else begin : g_asyncRead
      assign compare = accept;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cmpCnt <= '0;
    end else if (compare && (cmpCnt != FULL_CNT)) begin
      cmpCnt <= cmpCnt + ONE_CNT;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      doneQ <= 1'b0;
    end else if (strobe.lastCmp) begin
      doneQ <= 1'b1;
    end
  end

  assign strobe.accept  = accept;
  assign strobe.compare = compare;
  assign strobe.lastCmp = compare && (cmpCnt == LAST_CMP);
  assign checkDone      = doneQ;

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    accept |=> (acceptCnt == CNT_W'($past(acceptCnt) + ONE_CNT))); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !byteValid |=> $stable(acceptCnt)); // R9
  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (rst)
    full |=> $stable(acceptCnt)); // R7
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    doneQ |=> doneQ); // R6
  AST_DONE_AFTER_FULL: assert property (@(posedge clk) disable iff (rst)
    doneQ |-> full); // R6

endmodule

// File: rtl/echo_verify_dp.sv
module echo_verify_dp
  import echo_verify_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int READ_LAT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  ctlStrobe_t        strobe,
  input  logic [DATA_W-1:0] echoByte,
  input  logic [DATA_W-1:0] memRdData,
  output logic              errFlag
);

  logic [DATA_W-1:0] cmpByte;
  logic              mismatch;
  logic              errQ;

  generate
    if (READ_LAT == 1) begin : g_hold
      logic [DATA_W-1:0] holdByte;
      always_ff @(posedge clk) begin
        if (rst)                holdByte <= '0;
        else if (strobe.accept) holdByte <= echoByte;
      end
      assign cmpByte = holdByte;
    end else begin : g_direct
      assign cmpByte = echoByte;
    end
  endgenerate

  assign mismatch = strobe.compare && (cmpByte != memRdData);

  always_ff @(posedge clk) begin
    if (rst)           errQ <= 1'b0;
    else if (mismatch) errQ <= 1'b1;
  end

  assign errFlag = errQ;

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    errQ |=> errQ); // R4
  AST_ERR_ONLY_ON_CMP: assert property (@(posedge clk) disable iff (rst)
    !strobe.compare |=> (errQ == $past(errQ))); // R9

endmodule

// File: rtl/echo_verify.sv
module echo_verify
  import echo_verify_pkg::*;
#(
  parameter int DEPTH    = 4,
  parameter int DATA_W   = 8,
  parameter int READ_LAT = 1,
  localparam int ADDR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byteValid,
  input  logic [DATA_W-1:0] echoByte,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memRdData,
  output logic              checkDone,
  output logic              txGood
);

  ctlStrobe_t strobe;
  logic       errFlag;

  echo_verify_ctl #(
    .DEPTH    (DEPTH),
    .READ_LAT (READ_LAT)
  ) u_ctl (
    .clk       (clk),
    .rst       (rst),
    .byteValid (byteValid),
    .memAddr   (memAddr),
    .strobe    (strobe),
    .checkDone (checkDone)
  );

  echo_verify_dp #(
    .DATA_W   (DATA_W),
    .READ_LAT (READ_LAT)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .echoByte  (echoByte),
    .memRdData (memRdData),
    .errFlag   (errFlag)
  );

  assign txGood = checkDone && !errFlag;

  AST_GOOD_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst)
    txGood |-> checkDone); // R5
  AST_GOOD_STICKY: assert property (@(posedge clk) disable iff (rst)
    txGood |=> txGood); // R5

endmodule

// File: tb/echo_verify_bench.sv
module echo_verify_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       byteValid = 1'b0;
  logic [7:0] echoByte = 8'h00;
  logic [1:0] memAddr;
  logic [7:0] memRdData;
  logic       checkDone;
  logic       txGood;

  logic [7:0] mem [4];
  int nChk = 0;
  int nFail = 0;

  always #2.5 clk = ~clk;

  // Reference memory with one cycle of read latency
  always_ff @(posedge clk) memRdData <= mem[memAddr];

  echo_verify u_echo_verify (
    .clk       (clk),
    .rst       (rst),
    .byteValid (byteValid),
    .echoByte  (echoByte),
    .memAddr   (memAddr),
    .memRdData (memRdData),
    .checkDone (checkDone),
    .txGood    (txGood)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    byteValid = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(memAddr == 2'd0, "R1 addr", memAddr, 0);
    chk(checkDone == 1'b0, "R1 done", checkDone, 0);
    chk(txGood == 1'b0, "R1 good", txGood, 0);
    rst = 1'b0;
  endtask

  // Called at a negedge; returns at the negedge after the accepting edge.
  task automatic sendByte(input logic [7:0] b);
    byteValid = 1'b1;
    echoByte = b;
    @(posedge clk);
    @(negedge clk);
    byteValid = 1'b0;
  endtask

  task automatic runCase(input logic [31:0] echo, input int gap, input bit expGood);
    doReset();
    for (int i = 0; i < 4; i++) begin
      sendByte(echo[8*i +: 8]);
      chk(memAddr == 2'((i + 1) % 4), "R2 addr step", memAddr, (i + 1) % 4);
      if (i < 3) begin
        chk(checkDone == 1'b0, "R6 early done", checkDone, 0);
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          chk(memAddr == 2'(i + 1), "R9 idle addr", memAddr, i + 1);
          chk(checkDone == 1'b0, "R9 idle done", checkDone, 0);
        end
      end
    end
    chk(checkDone == 1'b0, "R6 done latency", checkDone, 0);
    @(negedge clk);
    chk(checkDone == 1'b1, "R6 done", checkDone, 1);
    chk(txGood == expGood, expGood ? "R5 good" : "R4 mismatch", txGood, expGood);
    // Overrun bytes
    sendByte(~echo[7:0]);
    sendByte(echo[15:8] ^ 8'h5a);
    @(negedge clk);
    chk(memAddr == 2'd0, "R7 addr", memAddr, 0);
    chk(checkDone == 1'b1, "R7 done", checkDone, 1);
    chk(txGood == expGood, "R7 good", txGood, expGood);
    repeat (3) @(negedge clk);
    chk(txGood == expGood, "R5 hold", txGood, expGood);
  endtask

  function automatic logic [31:0] memWord();
    return {mem[3], mem[2], mem[1], mem[0]};
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChk++;
    nFail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    summary();
    $finish;
  end

  initial begin
    for (int j = 0; j < 4; j++) mem[j] = 8'h00;
    // Matching streams, R3 and R5
    for (int p = 0; p < 6; p++) begin
      for (int j = 0; j < 4; j++) mem[j] = 8'((p * 37 + j * 71 + 3) & 255);
      runCase(memWord(), p % 3, 1'b1);
    end
    // Single-bit mismatch sweep, R4 and R3
    for (int j = 0; j < 4; j++) mem[j] = 8'(8'hc3 ^ (j * 29));
    for (int pos = 0; pos < 4; pos++) begin
      for (int bitI = 0; bitI < 8; bitI++) begin
        logic [31:0] e;
        e = memWord();
        e[pos * 8 + bitI] = ~e[pos * 8 + bitI];
        runCase(e, bitI % 3, 1'b0);
      end
    end
    // Swapped order fails: R3 compares against the same address
    runCase({mem[2], mem[3], mem[0], mem[1]}, 0, 1'b0);
    // Reset in mid transfer, R8
    doReset();
    sendByte(~mem[0]);
    sendByte(~mem[1]);
    doReset();
    chk(memAddr == 2'd0, "R8 addr", memAddr, 0);
    for (int i = 0; i < 4; i++) sendByte(mem[i]);
    @(negedge clk);
    chk(checkDone == 1'b1, "R8 done", checkDone, 1);
    chk(txGood == 1'b1, "R8 good", txGood, 1);
    summary();
    $finish;
  end

endmodule